// File: doc/BRIEF.md
# Synchronous Burst SRAM Bank

This block is one bank of a flow-through synchronous burst static memory. It holds 2^ADDR_W words of 72 bits. Each word has eight data bytes and one parity bit per byte. On every rising clock edge it samples the address, the bank enable, two address-start strobes, the advance input, the global write and the byte write controls. It then classifies the cycle as sleep, deselect, start, continue, suspend or idle.

A start loads a new external address. Continue and suspend cycles take their address from an internal two-bit burst sequencer, which steps either linearly or in interleaved order. Writes go into the array at the sampling edge, with a byte mask. Read data flows straight from the array at the registered address, with no output register. It is gated by an asynchronous active-low output enable.

The tri-state output of a memory bank is modelled here as a data bus plus a drive flag. A high-impedance output appears as `drive_o` low, with `rdata_o` at zero.

Top module: `sram_burst_bank`

## Requirements
- R1: After reset, `drive_o` is low. No burst is active, so continue and suspend cycles do nothing until a start cycle occurs.
- R2: A cycle with `ctrl_stb_n_i` low and `bank_en_n_i` high deselects the bank. From that edge on, `drive_o` is low, and later continue and suspend cycles do nothing until the next start.
- R3: A cycle with `proc_stb_n_i` low and `bank_en_n_i` low loads `addr_i` and starts a read, whatever the write controls are. With `bank_en_n_i` high, `proc_stb_n_i` is ignored.
- R4: A cycle with `ctrl_stb_n_i` low, `bank_en_n_i` low and `proc_stb_n_i` high loads `addr_i`. It is a write when `gwr_n_i` is low or `bmode_n_i` is low, and a read otherwise.
- R5: A write with `gwr_n_i` low stores all 72 bits of `wdata_i`, whatever `bmode_n_i` and `bwe_n_i` are.
- R6: A write with `gwr_n_i` high and `bmode_n_i` low stores byte k for each k where `bwe_n_i[k]` is low. Byte k is `wdata_i[8k+7:8k]` together with its parity bit `wdata_i[64+k]`. When all of `bwe_n_i` are high, nothing is stored.
- R7: When `interleave_i` was low at the start, each continue cycle adds 1 modulo 4 to the two low address bits. The upper address bits do not change.
- R8: When `interleave_i` was high at the start, the two low address bits on the n-th continue are the start value XOR (n mod 4).
- R9: When both strobes are high during a burst, `adv_n_i` low means continue (next address) and `adv_n_i` high means suspend (same address). The access is a write under the R4 write rule and a read otherwise.
- R10: `drive_o` is high only while `oe_n_i` is low, `snooze_i` is low and the last sampled cycle was a read. It follows `oe_n_i` without waiting for a clock.
- R11: A cycle with `snooze_i` high performs no access and ends any burst. While `snooze_i` is high, `drive_o` is low.
- R12: After a read edge, `rdata_o` holds the array word at that cycle's address within the same clock cycle.
- R13: Deselect, snooze, idle and read cycles leave the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr_i | input | ADDR_W | External word address |
| bank_en_n_i | input | 1 | Active-low bank enable |
| proc_stb_n_i | input | 1 | Active-low read-start strobe, gated by the bank enable |
| ctrl_stb_n_i | input | 1 | Active-low start or deselect strobe |
| adv_n_i | input | 1 | Active-low burst advance |
| gwr_n_i | input | 1 | Active-low global write of all 72 bits |
| bmode_n_i | input | 1 | Active-low byte write mode |
| bwe_n_i | input | 8 | Active-low per-byte write enables |
| wdata_i | input | 72 | Write data: bytes in bits 63:0, parity bits in 71:64 |
| interleave_i | input | 1 | Burst order sampled at start: 1 interleaved, 0 linear |
| snooze_i | input | 1 | Active-high standby |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| rdata_o | output | 72 | Read data, zero when not driving |
| drive_o | output | 1 | High when the bank drives read data |

## Verification
The assertions check these properties on every cycle:
- the output enable and snooze gating of the drive flag;
- the quiet output after a deselect;
- the absence of array writes during snooze and during read-start cycles;
- the full mask of a global write;
- a frozen address on suspend;
- the linear step of the burst address.

Only the bench scenarios can show that the right data reaches the right word:
- byte-lane and parity placement of partial writes;
- the interleaved order and the wrap of the burst;
- the contents being untouched after deselect and snooze;
- the flow-through timing of read data against a reference array.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
    localparam int LANES   = 8;
    localparam int BYTE_W  = 8;
    localparam int LANE_W  = BYTE_W + 1;
    localparam int DATA_W  = LANES * LANE_W;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_SLEEP,
        CYC_DESEL,
        CYC_START,
        CYC_CONT,
        CYC_SUSP
    } cyc_kind_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
    import sram_bank_pkg::*;
(
    input  logic             snooze_i,
    input  logic             bank_en_n_i,
    input  logic             proc_stb_n_i,
    input  logic             ctrl_stb_n_i,
    input  logic             adv_n_i,
    input  logic             gwr_n_i,
    input  logic             bmode_n_i,
    input  logic [LANES-1:0] bwe_n_i,
    input  logic             burst_live_i,
    output cyc_kind_e        kind_o,
    output logic             write_o,
    output logic [LANES-1:0] mask_o
);
    logic wr_req;

    always_comb begin
        wr_req = !gwr_n_i || !bmode_n_i;
        if (!gwr_n_i) begin
            mask_o = '1;
        end else if (!bmode_n_i) begin
            mask_o = ~bwe_n_i;
        end else begin
            mask_o = '0;
        end
    end

    always_comb begin
        kind_o  = CYC_IDLE;
        write_o = 1'b0;
        if (snooze_i) begin
            kind_o = CYC_SLEEP;
        end else if (!ctrl_stb_n_i && bank_en_n_i) begin
            kind_o = CYC_DESEL;
        end else if (!proc_stb_n_i && !bank_en_n_i) begin
            kind_o  = CYC_START;
            write_o = 1'b0;
        end else if (!ctrl_stb_n_i) begin
            kind_o  = CYC_START;
            write_o = wr_req;
        end else if (burst_live_i) begin
            kind_o  = adv_n_i ? CYC_SUSP : CYC_CONT;
            write_o = wr_req;
        end
    end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base_i,
    input  logic [BURST_W-1:0] step_i,
    input  logic               ilv_i,
    output logic [BURST_W-1:0] low_o
);
    logic [BURST_W-1:0] lin_low;
    logic [BURST_W-1:0] ilv_low;

    always_comb begin
        lin_low = base_i + step_i;
        ilv_low = base_i ^ step_i;
        low_o   = ilv_i ? ilv_low : lin_low;
    end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wlane_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rlane_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && mask_i[k]) begin
                cells[waddr_i] <= wlane_i[k*LANE_W +: LANE_W];
            end
        end

        assign rlane_o[k*LANE_W +: LANE_W] = cells[raddr_i];
    end
endmodule

// File: rtl/sram_burst_bank.sv
module sram_burst_bank
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bank_en_n_i,
    input  logic              proc_stb_n_i,
    input  logic              ctrl_stb_n_i,
    input  logic              adv_n_i,
    input  logic              gwr_n_i,
    input  logic              bmode_n_i,
    input  logic [LANES-1:0]  bwe_n_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              interleave_i,
    input  logic              snooze_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    localparam int BYTES_BITS = LANES * BYTE_W;

    typedef struct packed {
        logic               live;
        logic               rd;
        logic               ilv;
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] step;
        logic [ADDR_W-1:0]  acc;
    } bank_st_t;

    bank_st_t           st_d, st_q;
    cyc_kind_e          kind;
    logic               is_write;
    logic [LANES-1:0]   lane_mask;
    logic [BURST_W-1:0] step_nx;
    logic [BURST_W-1:0] seq_low;
    logic               arr_we;
    logic [DATA_W-1:0]  wlane;
    logic [DATA_W-1:0]  rlane;
    logic [DATA_W-1:0]  rword;

    sram_cycle_decode u_dec (
        .snooze_i     (snooze_i),
        .bank_en_n_i  (bank_en_n_i),
        .proc_stb_n_i (proc_stb_n_i),
        .ctrl_stb_n_i (ctrl_stb_n_i),
        .adv_n_i      (adv_n_i),
        .gwr_n_i      (gwr_n_i),
        .bmode_n_i    (bmode_n_i),
        .bwe_n_i      (bwe_n_i),
        .burst_live_i (st_q.live),
        .kind_o       (kind),
        .write_o      (is_write),
        .mask_o       (lane_mask)
    );

    assign step_nx = (kind == CYC_CONT) ? st_q.step + BURST_W'(1) : st_q.step;

    sram_burst_seq #(.BURST_W(BURST_W)) u_seq (
        .base_i (st_q.base),
        .step_i (step_nx),
        .ilv_i  (st_q.ilv),
        .low_o  (seq_low)
    );

    always_comb begin
        st_d   = st_q;
        arr_we = 1'b0;
        unique case (kind)
            CYC_SLEEP, CYC_DESEL: begin
                st_d.live = 1'b0;
                st_d.rd   = 1'b0;
            end
            CYC_START: begin
                st_d.live = 1'b1;
                st_d.ilv  = interleave_i;
                st_d.base = addr_i[BURST_W-1:0];
                st_d.step = '0;
                st_d.acc  = addr_i;
                st_d.rd   = !is_write;
                arr_we    = is_write;
            end
            CYC_CONT: begin
                st_d.step = step_nx;
                st_d.acc  = {st_q.acc[ADDR_W-1:BURST_W], seq_low};
                st_d.rd   = !is_write;
                arr_we    = is_write;
            end
            CYC_SUSP: begin
                st_d.rd = !is_write;
                arr_we  = is_write;
            end
            default: begin
                st_d.rd = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_pack
        assign wlane[k*LANE_W +: LANE_W] = {wdata_i[BYTES_BITS + k], wdata_i[k*BYTE_W +: BYTE_W]};
        assign rword[k*BYTE_W +: BYTE_W] = rlane[k*LANE_W +: BYTE_W];
        assign rword[BYTES_BITS + k]     = rlane[k*LANE_W + BYTE_W];
    end

    sram_byte_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .we_i    (arr_we),
        .mask_i  (lane_mask),
        .waddr_i (st_d.acc),
        .wlane_i (wlane),
        .raddr_i (st_q.acc),
        .rlane_o (rlane)
    );

    assign drive_o = st_q.rd && !oe_n_i && !snooze_i;
    assign rdata_o = drive_o ? rword : '0;
endmodule

// File: rtl/sram_bank_chk.sv
module sram_bank_chk
    import sram_bank_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_en_n_i,
    input logic              proc_stb_n_i,
    input logic              ctrl_stb_n_i,
    input logic              gwr_n_i,
    input logic              snooze_i,
    input logic              oe_n_i,
    input logic              drive_o,
    input logic              arr_we,
    input logic [LANES-1:0]  lane_mask,
    input cyc_kind_e         kind,
    input logic              ilv_q,
    input logic [ADDR_W-1:0] acc_q
);
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n_i || snooze_i) |-> !drive_o); // R10

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze_i && !ctrl_stb_n_i && bank_en_n_i) |=> !drive_o); // R2

    AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        snooze_i |-> !arr_we); // R11

    AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!snooze_i && !proc_stb_n_i && !bank_en_n_i) |-> !arr_we); // R3

    AST_GLOBAL_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !gwr_n_i) |-> (&lane_mask)); // R5

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_SUSP) |=> $stable(acc_q)); // R9

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_CONT && !ilv_q) |=>
        (acc_q[BURST_W-1:0] == BURST_W'($past(acc_q[BURST_W-1:0]) + 1'b1))); // R7
endmodule

bind sram_burst_bank sram_bank_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_en_n_i  (bank_en_n_i),
    .proc_stb_n_i (proc_stb_n_i),
    .ctrl_stb_n_i (ctrl_stb_n_i),
    .gwr_n_i      (gwr_n_i),
    .snooze_i     (snooze_i),
    .oe_n_i       (oe_n_i),
    .drive_o      (drive_o),
    .arr_we       (arr_we),
    .lane_mask    (lane_mask),
    .kind         (kind),
    .ilv_q        (st_q.ilv),
    .acc_q        (st_q.acc)
);

// File: tb/tb_sram_burst_bank.sv
`timescale 1ns/100ps
module tb_sram_burst_bank;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [AW-1:0] addr;
    logic        en_n, proc_n, ctrl_n, adv_n, gw_n, bm_n, ilv, snz, oe_n;
    logic [7:0]  bwe_n;
    logic [71:0] wd;
    logic [71:0] rdata;
    logic        drv;

    int n_chk  = 0;
    int n_fail = 0;

    logic [71:0] mm [0:(1<<AW)-1];
    bit m_live = 0, m_rd = 0, m_ilv = 0;
    int m_base = 0, m_step = 0, m_acc = 0;

    always #2.5 clk = ~clk;

    sram_burst_bank #(.ADDR_W(AW), .BURST_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .bank_en_n_i(en_n),
        .proc_stb_n_i(proc_n), .ctrl_stb_n_i(ctrl_n), .adv_n_i(adv_n),
        .gwr_n_i(gw_n), .bmode_n_i(bm_n), .bwe_n_i(bwe_n), .wdata_i(wd),
        .interleave_i(ilv), .snooze_i(snz), .oe_n_i(oe_n),
        .rdata_o(rdata), .drive_o(drv)
    );

    function automatic logic [71:0] pat(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {8'(a * 13 + 7), {4{b, ~b}}};
    endfunction

    task automatic check(input string req, input string what, input logic [71:0] got, input logic [71:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_edge();
        bit wr;
        bit wr_req;
        wr_req = !gw_n || !bm_n;
        wr = 0;
        if (snz) begin
            m_live = 0; m_rd = 0;
        end else if (!ctrl_n && en_n) begin
            m_live = 0; m_rd = 0;
        end else if ((!proc_n && !en_n) || !ctrl_n) begin
            m_live = 1; m_ilv = ilv; m_base = addr % 4; m_step = 0; m_acc = addr;
            wr = (!proc_n && !en_n) ? 0 : wr_req;
            m_rd = !wr;
        end else if (m_live) begin
            if (!adv_n) begin
                m_step = (m_step + 1) % 4;
                m_acc = (m_acc / 4) * 4 + (m_ilv ? (m_base ^ m_step) : ((m_base + m_step) % 4));
            end
            wr = wr_req;
            m_rd = !wr;
        end else begin
            m_rd = 0;
        end
        if (wr) begin
            for (int k = 0; k < 8; k++) begin
                if (!gw_n || !bwe_n[k]) begin
                    mm[m_acc][k*8 +: 8] = wd[k*8 +: 8];
                    mm[m_acc][64+k]     = wd[64+k];
                end
            end
        end
    endtask

    task automatic compare(input string req);
        bit ed;
        ed = m_rd && !oe_n && !snz;
        check(req, "drive", {71'd0, drv}, {71'd0, ed});
        check(req, "data", rdata, ed ? mm[m_acc] : 72'd0);
    endtask

    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic quiet();
        proc_n = 1; ctrl_n = 1; adv_n = 1; gw_n = 1; bm_n = 1; bwe_n = 8'hFF; en_n = 1;
    endtask

    task automatic start_c(input int a, input bit g, input bit b, input logic [7:0] be, input logic [71:0] d, input string req);
        quiet(); en_n = 0; ctrl_n = 0; addr = AW'(a); gw_n = g; bm_n = b; bwe_n = be; wd = d;
        step(req);
    endtask

    task automatic start_p(input int a, input string req);
        quiet(); en_n = 0; proc_n = 0; addr = AW'(a); gw_n = 0; bm_n = 0; bwe_n = 8'h00;
        step(req);
    endtask

    task automatic burst(input bit adv, input bit g, input logic [71:0] d, input string req);
        quiet(); adv_n = adv; gw_n = g; wd = d;
        step(req);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; quiet(); addr = '0; wd = '0; ilv = 0; snz = 0; oe_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare("R1");
        burst(0, 1, '0, "R1");
        burst(1, 1, '0, "R1");

        for (int a = 0; a < 16; a++) start_c(a, 0, 1, 8'hFF, pat(a), "R4/R5");
        start_c(20, 0, 0, 8'h5A, pat(20), "R5");

        start_p(3, "R3/R12");
        start_p(9, "R3/R12");
        start_p(20, "R5/R12");
        start_c(12, 1, 1, 8'h00, pat(99), "R4/R13");
        start_p(12, "R13");

        ilv = 0;
        start_p(5, "R7");
        for (int i = 0; i < 5; i++) burst(0, 1, '0, "R7");
        burst(1, 1, '0, "R9");
        burst(1, 1, '0, "R9");
        burst(0, 1, '0, "R7");

        ilv = 1;
        start_p(6, "R8");
        for (int i = 0; i < 5; i++) burst(0, 1, '0, "R8");
        ilv = 0;

        start_c(9, 0, 1, 8'hFF, pat(101), "R9");
        burst(0, 0, pat(102), "R9");
        burst(1, 0, pat(103), "R9");
        burst(0, 0, pat(104), "R9");
        start_p(9, "R9");
        for (int i = 0; i < 3; i++) burst(0, 1, '0, "R9");

        start_c(2, 1, 0, 8'b1010_0110, 72'h5A_0123456789ABCDEF, "R6");
        start_c(1, 1, 0, 8'h7F, 72'hC3_FEDCBA9876543210, "R6");
        start_c(3, 1, 0, 8'hFF, 72'h00_0000000000000000, "R6");
        start_p(0, "R6");
        for (int i = 0; i < 3; i++) burst(0, 1, '0, "R6");

        start_p(4, "R2");
        quiet(); ctrl_n = 0; en_n = 1; gw_n = 0; addr = AW'(4); wd = pat(77);
        step("R2/R13");
        burst(0, 0, pat(78), "R2/R13");
        burst(1, 1, '0, "R2");
        quiet(); proc_n = 0; en_n = 1; addr = AW'(7);
        step("R3");
        start_p(4, "R13");

        start_p(10, "R11");
        snz = 1;
        quiet(); en_n = 0; ctrl_n = 0; gw_n = 0; addr = AW'(10); wd = pat(55);
        step("R11/R13");
        burst(0, 0, pat(56), "R11");
        snz = 0;
        burst(0, 1, '0, "R11");
        start_p(10, "R13");

        start_p(11, "R10");
        oe_n = 1; #0.5;
        check("R10", "async off", {71'd0, drv}, 72'd0);
        check("R10", "async data", rdata, 72'd0);
        oe_n = 0; #0.5;
        check("R10", "async on", {71'd0, drv}, 72'd1);
        check("R10", "async data on", rdata, mm[11]);
        snz = 1; #0.5;
        check("R11", "snooze gate", {71'd0, drv}, 72'd0);
        snz = 0;
        @(negedge clk);
        compare("R10");
        oe_n = 1;
        start_p(13, "R10");
        oe_n = 0;
        quiet();
        step("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule